// File: doc/BRIEF.md
# Reservation Station Scheduler

This block is the waiting room of an out-of-order core. A front end hands it decoded instructions one per cycle in program order. Each instruction names two sources. A source is either already available or still waiting on a producer, and the producer is identified by a tag. The pool keeps each instruction until both of its operands are available. It then sends the instruction to a functional unit of the right kind, as soon as one of those units is idle.

Every cycle runs in a fixed order. First the block compares the completion broadcasts against every waiting source tag. Then, for each unit class, it picks the oldest entry that is ready. Last, it accepts a new instruction into a free slot, and that slot may be one that a fire has just emptied. A result that is broadcast in a cycle can therefore release a dependent instruction in that same cycle. The fired instruction leaves on the per-class output combinationally, and its slot is freed at the next clock edge. Decode, the functional units and the register status table all sit outside the block.

Top module: `rs_scheduler`

## Requirements
- R1: After reset the pool is empty: `disp_ready` is 1 and every bit of `fire_valid` is 0.
- R2: `disp_ready` is 0 exactly when all `ENTRIES` slots are occupied and no entry fires in that cycle. An instruction presented while `disp_ready` is 0 is dropped and never fires.
- R3: Opcodes map to unit classes as follows: 0 (add) and 1 (sub) go to class 0 (ALU). 2 (mul) goes to class 1. 3 (load) and 4 (store) go to class 2 (memory). Values 5 to 7 go to class 0. An entry fires on class c only when both of its source ready bits are set and `fu_free[c]` is 1.
- R4: A firing entry shows its opcode, sequence number, destination register, destination tag and both source register/tag pairs on the slice of the fire outputs for its class, in that same cycle. The entry is gone from the pool after the clock edge.
- R5: A valid broadcast lane whose tag equals a waiting source tag sets that source's ready bit, and the bit stays set until the entry fires. The match is also seen combinationally, so the woken entry can fire in the broadcast cycle. A lane whose valid bit is 0 wakes nothing.
- R6: All `NBC` lanes are compared against both sources of every entry in the same cycle, so one cycle can wake both sources of an entry.
- R7: When an instruction is dispatched in the same cycle as a valid broadcast that matches one of its source tags, that source is stored as ready.
- R8: When several entries are eligible for the same class, the one with the smallest sequence number fires. The comparison is a plain unsigned one, and sequence numbers must not wrap while the older entry is still in the pool.
- R9: When the pool is full and an entry fires, a dispatch in the same cycle is accepted into the slot being freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is presented |
| disp_ready | output | 1 | The presented instruction is taken this cycle |
| disp_op | input | 3 | Opcode |
| disp_seq | input | SEQ_W | Program-order sequence number |
| disp_dst_reg | input | REG_W | Destination register |
| disp_dst_tag | input | TAG_W | Tag the result will be broadcast with |
| disp_src1_reg | input | REG_W | First source register |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src1_tag | input | TAG_W | Producer tag of first source |
| disp_src2_reg | input | REG_W | Second source register |
| disp_src2_rdy | input | 1 | Second source already available |
| disp_src2_tag | input | TAG_W | Producer tag of second source |
| bc_valid | input | NBC | Completion broadcast valid, one bit per lane |
| bc_tag | input | NBC*TAG_W | Completion tag per lane |
| fu_free | input | 3 | An idle unit exists, per class |
| fire_valid | output | 3 | An entry fires, per class |
| fire_op | output | 3*3 | Opcode per class |
| fire_seq | output | 3*SEQ_W | Sequence number per class |
| fire_dst_reg | output | 3*REG_W | Destination register per class |
| fire_dst_tag | output | 3*TAG_W | Destination tag per class |
| fire_src1_reg | output | 3*REG_W | First source register per class |
| fire_src1_tag | output | 3*TAG_W | First source tag per class |
| fire_src2_reg | output | 3*REG_W | Second source register per class |
| fire_src2_tag | output | 3*TAG_W | Second source tag per class |

## Verification
The bench targets the same-cycle paths. A broadcast has to release an entry in the cycle it arrives; a design that only registers the wakeup would fire one cycle late. A dispatch that meets a matching broadcast has to capture the source as ready; a design that misses this leaves the entry waiting forever. A full pool has to take a new instruction into the slot a fire is emptying; a design without this holds `disp_ready` low for one cycle too many. The bench also checks oldest-first selection among several ready entries, wakeup of both sources by two lanes in one cycle, lanes whose valid bit is low, and a dispatch attempted while the pool is full. A wrong arbiter shows up as the wrong sequence number on a fire output, and a leaky full check shows up later as an extra fire.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int OP_W      = 3;
    localparam int NUM_CLASS = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_LD  = 3'd3,
        OP_ST  = 3'd4
    } opcode_e;

    typedef enum logic [1:0] {
        CL_ALU = 2'd0,
        CL_MUL = 2'd1,
        CL_MEM = 2'd2
    } fu_class_e;

    function automatic logic [1:0] op_class(input logic [OP_W-1:0] op);
        case (op)
            OP_MUL:        op_class = CL_MUL;
            OP_LD, OP_ST:  op_class = CL_MEM;
            default:       op_class = CL_ALU;
        endcase
    endfunction

endpackage

// File: rtl/rs_wakeup.sv
module rs_wakeup #(
    parameter int N_SRC = 4,
    parameter int TAG_W = 5,
    parameter int NBC   = 2
) (
    input  logic [N_SRC*TAG_W-1:0] src_tag,
    input  logic [N_SRC-1:0]       src_rdy,
    input  logic [NBC-1:0]         bc_valid,
    input  logic [NBC*TAG_W-1:0]   bc_tag,
    output logic [N_SRC-1:0]       rdy_out
);

    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            rdy_out[s] = src_rdy[s];
            for (int b = 0; b < NBC; b++) begin
                if (bc_valid[b] && (bc_tag[b*TAG_W +: TAG_W] == src_tag[s*TAG_W +: TAG_W]))
                    rdy_out[s] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 10
) (
    input  logic [ENTRIES-1:0]       elig,
    input  logic [ENTRIES*SEQ_W-1:0] seq,
    output logic [ENTRIES-1:0]       gnt,
    output logic                     any
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [SEQ_W-1:0] best;
    logic [IDX_W-1:0] sel;

    always_comb begin
        any  = 1'b0;
        best = '0;
        sel  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (elig[i] && (!any || (seq[i*SEQ_W +: SEQ_W] < best))) begin
                any  = 1'b1;
                best = seq[i*SEQ_W +: SEQ_W];
                sel  = IDX_W'(i);
            end
        end
        gnt = '0;
        if (any)
            gnt[sel] = 1'b1;
    end

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0] busy,
    output logic [ENTRIES-1:0] slot,
    output logic               any_free
);

    always_comb begin
        slot     = '0;
        any_free = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!busy[i] && !any_free) begin
                slot[i]  = 1'b1;
                any_free = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_scheduler.sv
module rs_scheduler
    import rs_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 5,
    parameter int TAG_W   = 5,
    parameter int SEQ_W   = 10,
    parameter int NBC     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       disp_valid,
    output logic                       disp_ready,
    input  logic [OP_W-1:0]            disp_op,
    input  logic [SEQ_W-1:0]           disp_seq,
    input  logic [REG_W-1:0]           disp_dst_reg,
    input  logic [TAG_W-1:0]           disp_dst_tag,
    input  logic [REG_W-1:0]           disp_src1_reg,
    input  logic                       disp_src1_rdy,
    input  logic [TAG_W-1:0]           disp_src1_tag,
    input  logic [REG_W-1:0]           disp_src2_reg,
    input  logic                       disp_src2_rdy,
    input  logic [TAG_W-1:0]           disp_src2_tag,
    input  logic [NBC-1:0]             bc_valid,
    input  logic [NBC*TAG_W-1:0]       bc_tag,
    input  logic [NUM_CLASS-1:0]       fu_free,
    output logic [NUM_CLASS-1:0]       fire_valid,
    output logic [NUM_CLASS*OP_W-1:0]  fire_op,
    output logic [NUM_CLASS*SEQ_W-1:0] fire_seq,
    output logic [NUM_CLASS*REG_W-1:0] fire_dst_reg,
    output logic [NUM_CLASS*TAG_W-1:0] fire_dst_tag,
    output logic [NUM_CLASS*REG_W-1:0] fire_src1_reg,
    output logic [NUM_CLASS*TAG_W-1:0] fire_src1_tag,
    output logic [NUM_CLASS*REG_W-1:0] fire_src2_reg,
    output logic [NUM_CLASS*TAG_W-1:0] fire_src2_tag
);

    localparam int N_SRC = 2 * ENTRIES + 2;
    localparam int CNT_W = $clog2(ENTRIES + 1) + 1;

    typedef struct packed {
        logic             vld;
        logic [OP_W-1:0]  op;
        logic [SEQ_W-1:0] seq;
        logic [REG_W-1:0] dreg;
        logic [TAG_W-1:0] dtag;
        logic [REG_W-1:0] r1;
        logic             k1;
        logic [TAG_W-1:0] t1;
        logic [REG_W-1:0] r2;
        logic             k2;
        logic [TAG_W-1:0] t2;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } state_t;

    state_t st_q, st_d;

    // ---------------- wakeup: pool sources plus the two dispatch sources
    logic [N_SRC*TAG_W-1:0] src_tag;
    logic [N_SRC-1:0]       src_rdy;
    logic [N_SRC-1:0]       woke;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            src_tag[(2*i)*TAG_W +: TAG_W]   = st_q.ent[i].t1;
            src_tag[(2*i+1)*TAG_W +: TAG_W] = st_q.ent[i].t2;
            src_rdy[2*i]                    = st_q.ent[i].k1;
            src_rdy[2*i+1]                  = st_q.ent[i].k2;
        end
        src_tag[(2*ENTRIES)*TAG_W +: TAG_W]   = disp_src1_tag;
        src_tag[(2*ENTRIES+1)*TAG_W +: TAG_W] = disp_src2_tag;
        src_rdy[2*ENTRIES]                    = disp_src1_rdy;
        src_rdy[2*ENTRIES+1]                  = disp_src2_rdy;
    end

    rs_wakeup #(.N_SRC(N_SRC), .TAG_W(TAG_W), .NBC(NBC)) u_wakeup (
        .src_tag  (src_tag),
        .src_rdy  (src_rdy),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .rdy_out  (woke)
    );

    // ---------------- eligibility and per-class selection
    logic [NUM_CLASS-1:0][ENTRIES-1:0] elig;
    logic [NUM_CLASS-1:0][ENTRIES-1:0] gnt;
    logic [ENTRIES*SEQ_W-1:0]          seq_flat;
    logic [ENTRIES-1:0]                fired;
    logic [ENTRIES-1:0]                valid_q;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            seq_flat[i*SEQ_W +: SEQ_W] = st_q.ent[i].seq;
            valid_q[i]                 = st_q.ent[i].vld;
        end
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                elig[c][i] = st_q.ent[i].vld && woke[2*i] && woke[2*i+1]
                          && (op_class(st_q.ent[i].op) == 2'(c)) && fu_free[c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        rs_pick #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_pick (
            .elig (elig[c]),
            .seq  (seq_flat),
            .gnt  (gnt[c]),
            .any  (fire_valid[c])
        );
    end

    // ---------------- fire output multiplexing
    always_comb begin
        fired         = '0;
        fire_op       = '0;
        fire_seq      = '0;
        fire_dst_reg  = '0;
        fire_dst_tag  = '0;
        fire_src1_reg = '0;
        fire_src1_tag = '0;
        fire_src2_reg = '0;
        fire_src2_tag = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            fired = fired | gnt[c];
            for (int i = 0; i < ENTRIES; i++) begin
                if (gnt[c][i]) begin
                    fire_op[c*OP_W +: OP_W]         = st_q.ent[i].op;
                    fire_seq[c*SEQ_W +: SEQ_W]      = st_q.ent[i].seq;
                    fire_dst_reg[c*REG_W +: REG_W]  = st_q.ent[i].dreg;
                    fire_dst_tag[c*TAG_W +: TAG_W]  = st_q.ent[i].dtag;
                    fire_src1_reg[c*REG_W +: REG_W] = st_q.ent[i].r1;
                    fire_src1_tag[c*TAG_W +: TAG_W] = st_q.ent[i].t1;
                    fire_src2_reg[c*REG_W +: REG_W] = st_q.ent[i].r2;
                    fire_src2_tag[c*TAG_W +: TAG_W] = st_q.ent[i].t2;
                end
            end
        end
    end

    // ---------------- allocation after firing
    logic [ENTRIES-1:0] slot;
    logic               any_free;
    logic               accept;

    rs_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .busy     (valid_q & ~fired),
        .slot     (slot),
        .any_free (any_free)
    );

    assign disp_ready = any_free;
    assign accept     = disp_valid && any_free;

    // ---------------- next state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.ent[i].k1 = woke[2*i];
            st_d.ent[i].k2 = woke[2*i+1];
            if (fired[i])
                st_d.ent[i].vld = 1'b0;
            if (accept && slot[i]) begin
                st_d.ent[i].vld  = 1'b1;
                st_d.ent[i].op   = disp_op;
                st_d.ent[i].seq  = disp_seq;
                st_d.ent[i].dreg = disp_dst_reg;
                st_d.ent[i].dtag = disp_dst_tag;
                st_d.ent[i].r1   = disp_src1_reg;
                st_d.ent[i].k1   = woke[2*ENTRIES];
                st_d.ent[i].t1   = disp_src1_tag;
                st_d.ent[i].r2   = disp_src2_reg;
                st_d.ent[i].k2   = woke[2*ENTRIES+1];
                st_d.ent[i].t2   = disp_src2_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // ---------------- assertions
    logic [CNT_W-1:0] occ_now, fire_cnt;
    assign occ_now  = CNT_W'($countones(valid_q));
    assign fire_cnt = CNT_W'($countones(fired));

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_chk
        a_r3_fire_needs_unit: assert property (@(posedge clk) disable iff (!rst_n)
            fire_valid[c] |-> fu_free[c]);
        a_r3_fire_class: assert property (@(posedge clk) disable iff (!rst_n)
            fire_valid[c] |-> (op_class(fire_op[c*OP_W +: OP_W]) == 2'(c)));
    end

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (&valid_q));

    a_r4_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (occ_now == $past(occ_now) - $past(fire_cnt) + CNT_W'($past(accept))));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_keep
        a_r5_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ent[i].vld && !fired[i] && !(accept && slot[i]) && st_q.ent[i].k1)
            |=> st_q.ent[i].k1);
    end

endmodule

// File: tb/rs_scheduler_bench.sv
module rs_scheduler_bench;
    import rs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 8;
    localparam int REG_W   = 5;
    localparam int TAG_W   = 5;
    localparam int SEQ_W   = 10;
    localparam int NBC     = 2;
    localparam int NCL     = NUM_CLASS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                   disp_valid = 0, disp_ready;
    logic [OP_W-1:0]        disp_op = 0;
    logic [SEQ_W-1:0]       disp_seq = 0;
    logic [REG_W-1:0]       disp_dst_reg = 0, disp_src1_reg = 0, disp_src2_reg = 0;
    logic [TAG_W-1:0]       disp_dst_tag = 0, disp_src1_tag = 0, disp_src2_tag = 0;
    logic                   disp_src1_rdy = 0, disp_src2_rdy = 0;
    logic [NBC-1:0]         bc_valid = 0;
    logic [NBC*TAG_W-1:0]   bc_tag = 0;
    logic [NCL-1:0]         fu_free = 0;
    logic [NCL-1:0]         fire_valid;
    logic [NCL*OP_W-1:0]    fire_op;
    logic [NCL*SEQ_W-1:0]   fire_seq;
    logic [NCL*REG_W-1:0]   fire_dst_reg, fire_src1_reg, fire_src2_reg;
    logic [NCL*TAG_W-1:0]   fire_dst_tag, fire_src1_tag, fire_src2_tag;

    rs_scheduler #(.ENTRIES(ENTRIES), .REG_W(REG_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .NBC(NBC))
    u_rs_scheduler (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_op(disp_op), .disp_seq(disp_seq),
        .disp_dst_reg(disp_dst_reg), .disp_dst_tag(disp_dst_tag),
        .disp_src1_reg(disp_src1_reg), .disp_src1_rdy(disp_src1_rdy), .disp_src1_tag(disp_src1_tag),
        .disp_src2_reg(disp_src2_reg), .disp_src2_rdy(disp_src2_rdy), .disp_src2_tag(disp_src2_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .fu_free(fu_free),
        .fire_valid(fire_valid), .fire_op(fire_op), .fire_seq(fire_seq),
        .fire_dst_reg(fire_dst_reg), .fire_dst_tag(fire_dst_tag),
        .fire_src1_reg(fire_src1_reg), .fire_src1_tag(fire_src1_tag),
        .fire_src2_reg(fire_src2_reg), .fire_src2_tag(fire_src2_tag)
    );

    int checks = 0;
    int failures = 0;
    int next_seq = 1;

    typedef struct {
        int op, seq, dreg, dtag, r1, k1, t1, r2, k2, t2;
    } m_ent_t;
    m_ent_t mq[$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cls(int op);
        if (op == 2) return 1;
        if (op == 3 || op == 4) return 2;
        return 0;
    endfunction

    function automatic int hit(int tag);
        for (int b = 0; b < NBC; b++)
            if (bc_valid[b] && int'(bc_tag[b*TAG_W +: TAG_W]) == tag) return 1;
        return 0;
    endfunction

    // One clock: compare against the reference model, then advance it.
    task automatic step();
        m_ent_t nq[$];
        int pick[NCL];
        bit exp_rdy;
        #1;
        foreach (mq[j]) begin
            if (hit(mq[j].t1) != 0) mq[j].k1 = 1;
            if (hit(mq[j].t2) != 0) mq[j].k2 = 1;
        end
        for (int c = 0; c < NCL; c++) begin
            pick[c] = -1;
            if (fu_free[c])
                foreach (mq[j])
                    if (cls(mq[j].op) == c && mq[j].k1 == 1 && mq[j].k2 == 1 &&
                        (pick[c] < 0 || mq[j].seq < mq[pick[c]].seq))
                        pick[c] = j;
            chk(fire_valid[c] == (pick[c] >= 0), "R3/R5", "fire_valid", fire_valid[c], pick[c] >= 0);
            if (pick[c] >= 0 && fire_valid[c]) begin
                m_ent_t e = mq[pick[c]];
                chk(int'(fire_seq[c*SEQ_W +: SEQ_W]) == e.seq, "R8", "fire_seq",
                    fire_seq[c*SEQ_W +: SEQ_W], e.seq);
                chk(int'(fire_op[c*OP_W +: OP_W]) == e.op &&
                    int'(fire_dst_reg[c*REG_W +: REG_W]) == e.dreg &&
                    int'(fire_dst_tag[c*TAG_W +: TAG_W]) == e.dtag &&
                    int'(fire_src1_reg[c*REG_W +: REG_W]) == e.r1 &&
                    int'(fire_src1_tag[c*TAG_W +: TAG_W]) == e.t1 &&
                    int'(fire_src2_reg[c*REG_W +: REG_W]) == e.r2 &&
                    int'(fire_src2_tag[c*TAG_W +: TAG_W]) == e.t2,
                    "R4", "fire fields of seq", fire_seq[c*SEQ_W +: SEQ_W], e.seq);
            end
        end
        foreach (mq[j]) begin
            bit gone = 0;
            for (int c = 0; c < NCL; c++) if (pick[c] == j) gone = 1;
            if (!gone) nq.push_back(mq[j]);
        end
        exp_rdy = (nq.size() < ENTRIES);
        chk(disp_ready == exp_rdy, "R2/R9", "disp_ready", disp_ready, exp_rdy);
        if (disp_valid && exp_rdy) begin
            m_ent_t n;
            n.op = disp_op; n.seq = disp_seq; n.dreg = disp_dst_reg; n.dtag = disp_dst_tag;
            n.r1 = disp_src1_reg; n.t1 = disp_src1_tag; n.r2 = disp_src2_reg; n.t2 = disp_src2_tag;
            n.k1 = (disp_src1_rdy || hit(disp_src1_tag) != 0) ? 1 : 0;   // R7
            n.k2 = (disp_src2_rdy || hit(disp_src2_tag) != 0) ? 1 : 0;
            nq.push_back(n);
        end
        mq = nq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic present(int op, bit k1, int t1, bit k2, int t2);
        disp_valid = 1; disp_op = OP_W'(op); disp_seq = SEQ_W'(next_seq);
        disp_dst_reg = REG_W'(next_seq % 32); disp_dst_tag = TAG_W'((next_seq + 9) % 32);
        disp_src1_reg = REG_W'(op + 3); disp_src1_rdy = k1; disp_src1_tag = TAG_W'(t1);
        disp_src2_reg = REG_W'(op + 7); disp_src2_rdy = k2; disp_src2_tag = TAG_W'(t2);
        next_seq++;
    endtask

    task automatic idle();
        disp_valid = 0; bc_valid = '0;
    endtask

    task automatic bcast(int lane, int tag);
        bc_valid[lane] = 1'b1;
        bc_tag[lane*TAG_W +: TAG_W] = TAG_W'(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(disp_ready == 1'b1, "R1", "disp_ready after reset", disp_ready, 1);
        chk(fire_valid == '0, "R1", "fire_valid after reset", fire_valid, 0);
        @(negedge clk);

        // R2: fill the pool with units busy, then try one more
        fu_free = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            present(k % 5, 1, 0, 1, 0);
            step();
        end
        present(0, 1, 0, 1, 0);          // R2: dropped, pool full
        step();
        #1 chk(disp_ready == 1'b0, "R2", "disp_ready when full", disp_ready, 0);
        // R9: a fire on ALU frees a slot that the same-cycle dispatch takes
        fu_free = 3'b001;
        present(2, 1, 0, 1, 0);
        step();
        // R8: release everything, oldest first per class
        idle();
        fu_free = 3'b111;
        repeat (5) step();
        chk(mq.size() == 0, "R2", "model drained", mq.size(), 0);

        // R5: wait on a tag, broadcast fires it the same cycle
        present(2, 0, 3, 1, 0);
        step();
        idle();
        bcast(1, 4); bc_valid[0] = 1'b0; bc_tag[0 +: TAG_W] = TAG_W'(3);  // R5: invalid lane ignored
        step();
        bc_valid = '0; bcast(0, 3);
        step();
        // R6: two lanes wake both sources at once
        idle();
        present(1, 0, 5, 0, 6);
        step();
        idle();
        bcast(0, 5); bcast(1, 6);
        step();
        // R5: sources woken in separate cycles keep their bits
        idle();
        present(0, 0, 8, 0, 9);
        step();
        idle(); bcast(0, 8);
        step();
        idle(); bcast(1, 9);
        step();
        // R7: dispatch meets its producer broadcast
        idle();
        fu_free = 3'b000;
        present(3, 0, 11, 1, 0);
        bcast(0, 11);
        step();
        idle();
        fu_free = 3'b100;
        step();
        step();

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            idle();
            if ($urandom_range(1, 0) == 1)
                present($urandom_range(4, 0), 1'($urandom_range(1, 0)), $urandom_range(7, 0),
                        1'($urandom_range(1, 0)), $urandom_range(7, 0));
            for (int b = 0; b < NBC; b++)
                if ($urandom_range(2, 0) != 0) bcast(b, $urandom_range(7, 0));
            fu_free = NCL'($urandom_range(7, 0));
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule